// File: doc/BRIEF.md
# Layered LDPC Check-Row Trellis Processor

This block updates one parity-check row of a layered decoder for quasi-cyclic LDPC codes. It does not search for a minimum in the usual way. Instead it treats the row as a two-state trellis whose length is the row weight. For each non-zero entry it receives the current bit LLR and the check message stored from the previous iteration. It forms the variable-to-check value Q, then runs a forward and a backward recursion built on the operator Phi(x,y) = max(x,y) - max(x+y,0). It returns, for every entry, the new check message and the refreshed bit LLR. The outputs come back in the same order as the inputs arrived.

Data enters as a serial stream of (LLR, old message) pairs over a valid/ready handshake. The row weight is given as a plain input and is sampled with the first beat of the row. Each row runs in three phases:
- A load phase accepts one beat per cycle and runs the forward recursion.
- A backward phase takes exactly one cycle per entry and needs no handshake.
- A drain phase returns the results under the output handshake.

Input beats are accepted only during the load phase. `in_ready` depends only on the phase and never on `in_valid`. On the output side, `out_valid` stays high and the data stays unchanged until `out_ready` takes the beat. Storage for the LLRs and messages, and the generation of their addresses, sit outside the block.

Top module: `ldpc_row_proc`

## Requirements
- R1: `row_wt` is sampled on the first accepted beat of a row and clamped to the range 2..MAXW (default 20): values below 2 count as 2 and values above MAXW count as MAXW. Exactly that many beats are accepted, and `in_ready` is low in the cycle after the last one.
- R2: For each entry, Q = sat(LLR - R_old) in DW-bit two's complement (default 10 bits, range -512..511), saturating at both ends. A zero R_old, as on a first iteration, gives Q equal to the LLR.
- R3: The forward metric starts from the most negative code (-512) and is updated as A_k = Phi(A_{k-1}, Q_k). The new message is R_k = Phi(A_{k-1}, B_{k+1}), where Phi(x,y) = max(x,y) - max(x+y,0) is saturated to DW bits.
- R4: The backward metric starts from the most negative code at the end of the row and is updated as B_k = Phi(B_{k+1}, Q_k), with k running from the last entry down to the first.
- R5: The returned LLR is sat(Q_k + R_k), saturated to DW bits. `out_rnew` carries R_k.
- R6: Exactly the row-weight number of result beats are returned, in input order. `out_valid` rises the row-weight number of cycles after the edge that took the last input beat. After the last result beat is taken, `in_ready` is high and `out_valid` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_lam` and `out_rnew` hold their values.
- R8: During and after reset, `in_ready` is 1 and `out_valid` is 0.
- R9: `in_ready` and `out_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_wt | input | CW (5) | Row weight, sampled with the first beat of a row |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block is in the load phase and accepts a beat |
| in_lam | input | DW (10) | Current bit LLR, signed |
| in_rold | input | DW (10) | Stored check message from the last iteration, signed |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream takes the result beat |
| out_lam | output | DW (10) | Updated bit LLR, signed |
| out_rnew | output | DW (10) | New check message, signed |

## Verification
A corrupted Q or forward-metric entry in the local store stays hidden until the drain phase. It then shows up as wrong messages for the neighbouring entries, because each message mixes the metrics from both sides of its entry. A wrong backward metric corrupts every earlier entry, so a fault near the end of the row spreads to the start of the output stream. Phase or counter faults show up sooner: at the handshake pins, as a wrong beat count, a missing drop of `in_ready`, or `out_valid` rising too early or too late. Rows at the minimum and maximum weight, clamped weights, saturating inputs and random output stalls are all needed to expose these faults.

// File: rtl/ldpc_row_pkg.sv
package ldpc_row_pkg;
  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_BACK  = 2'd1,
    PH_DRAIN = 2'd2
  } row_phase_e;
endpackage

// File: rtl/lrp_phi.sv
module lrp_phi #(
  parameter int DW = 10
) (
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] y,
  output logic signed [DW-1:0] z
);
  localparam int EW = DW + 2;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [EW-1:0] HI_E = EW'(MAXV);
  localparam logic signed [EW-1:0] LO_E = EW'(MINV);

  logic signed [EW-1:0] xe, ye, mx, sm, pos, d;

  always_comb begin
    xe  = EW'(x);
    ye  = EW'(y);
    mx  = (xe > ye) ? xe : ye;
    sm  = xe + ye;
    pos = (sm > 0) ? sm : '0;
    d   = mx - pos;
    if (d > HI_E)      z = MAXV;
    else if (d < LO_E) z = MINV;
    else               z = d[DW-1:0];
  end
endmodule

// File: rtl/lrp_satadd.sv
module lrp_satadd #(
  parameter int DW = 10
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic                 sub,
  output logic signed [DW-1:0] z
);
  localparam int EW = DW + 1;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [EW-1:0] HI_E = EW'(MAXV);
  localparam logic signed [EW-1:0] LO_E = EW'(MINV);

  logic signed [EW-1:0] s;

  always_comb begin
    s = sub ? (EW'(a) - EW'(b)) : (EW'(a) + EW'(b));
    if (s > HI_E)      z = MAXV;
    else if (s < LO_E) z = MINV;
    else               z = s[DW-1:0];
  end
endmodule

// File: rtl/lrp_recur.sv
module lrp_recur #(
  parameter int DW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 step,
  input  logic signed [DW-1:0] q_in,
  output logic signed [DW-1:0] prev
);
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] met_q, met_nxt;

  // the edge of the trellis enters at the most negative code
  assign prev = start ? MINV : met_q;

  lrp_phi #(.DW(DW)) u_phi (
    .x(prev),
    .y(q_in),
    .z(met_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    met_q <= MINV;
    else if (step) met_q <= met_nxt;
  end
endmodule

// File: rtl/lrp_store.sv
module lrp_store #(
  parameter int DW   = 10,
  parameter int MAXW = 20,
  parameter int CW   = $clog2(MAXW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 q_we,
  input  logic                 m_we,
  input  logic [CW-1:0]        waddr,
  input  logic signed [DW-1:0] q_wdata,
  input  logic signed [DW-1:0] m_wdata,
  input  logic [CW-1:0]        raddr,
  output logic signed [DW-1:0] q_rd,
  output logic signed [DW-1:0] m_rd
);
  logic signed [DW-1:0] q_r [MAXW];
  logic signed [DW-1:0] m_r [MAXW];

  for (genvar i = 0; i < MAXW; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r[i] <= '0;
        m_r[i] <= '0;
      end else begin
        if (q_we && waddr == CW'(i)) q_r[i] <= q_wdata;
        if (m_we && waddr == CW'(i)) m_r[i] <= m_wdata;
      end
    end
  end

  assign q_rd = q_r[raddr];
  assign m_rd = m_r[raddr];
endmodule

// File: rtl/lrp_ctrl.sv
module lrp_ctrl
  import ldpc_row_pkg::*;
#(
  parameter int MAXW = 20,
  parameter int CW   = $clog2(MAXW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] row_wt,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic [CW-1:0] idx,
  output logic          fwd_start,
  output logic          fwd_step,
  output logic          bwd_start,
  output logic          bwd_step
);
  row_phase_e    ph_q;
  logic [CW-1:0] idx_q, wt_q, wt_clamp, wt_eff;
  logic          in_fire, out_fire;

  always_comb begin
    if (row_wt < CW'(2))         wt_clamp = CW'(2);
    else if (row_wt > CW'(MAXW)) wt_clamp = CW'(MAXW);
    else                         wt_clamp = row_wt;
  end

  assign in_ready  = (ph_q == PH_LOAD);
  assign out_valid = (ph_q == PH_DRAIN);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign wt_eff    = (idx_q == '0) ? wt_clamp : wt_q;
  assign idx       = idx_q;
  assign fwd_start = in_ready && (idx_q == '0);
  assign fwd_step  = in_fire;
  assign bwd_step  = (ph_q == PH_BACK);
  assign bwd_start = bwd_step && (idx_q == wt_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_LOAD;
      idx_q <= '0;
      wt_q  <= CW'(2);
    end else begin
      unique case (ph_q)
        PH_LOAD: if (in_fire) begin
          if (idx_q == '0) wt_q <= wt_clamp;
          if (idx_q == wt_eff - CW'(1)) ph_q <= PH_BACK;
          else idx_q <= idx_q + CW'(1);
        end
        PH_BACK: begin
          if (idx_q == '0) ph_q <= PH_DRAIN;
          else idx_q <= idx_q - CW'(1);
        end
        PH_DRAIN: if (out_fire) begin
          if (idx_q == wt_q - CW'(1)) begin
            ph_q  <= PH_LOAD;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + CW'(1);
          end
        end
        default: ph_q <= PH_LOAD;
      endcase
    end
  end

  AST_WT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_LOAD) |-> (wt_q >= CW'(2) && wt_q <= CW'(MAXW))); // R1
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_LOAD) |-> (idx_q < wt_q)); // R6
  AST_BACK_TO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_step && idx_q == '0) |=> out_valid); // R6
  AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && idx_q == wt_q - CW'(1)) |=> (in_ready && !out_valid)); // R6
endmodule

// File: rtl/ldpc_row_proc.sv
module ldpc_row_proc #(
  parameter int DW   = 10,
  parameter int MAXW = 20,
  parameter int CW   = $clog2(MAXW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        row_wt,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_lam,
  input  logic signed [DW-1:0] in_rold,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_lam,
  output logic signed [DW-1:0] out_rnew
);
  logic [CW-1:0]        idx;
  logic                 fwd_start, fwd_step, bwd_start, bwd_step;
  logic signed [DW-1:0] q_new, alpha_prev, beta_prev, r_new;
  logic signed [DW-1:0] q_rd, m_rd, m_wdata, lam_upd;

  lrp_ctrl #(.MAXW(MAXW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .row_wt(row_wt),
    .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .idx(idx),
    .fwd_start(fwd_start), .fwd_step(fwd_step),
    .bwd_start(bwd_start), .bwd_step(bwd_step)
  );

  // Q = LLR - R_old, saturated
  lrp_satadd #(.DW(DW)) u_qsub (
    .a(in_lam), .b(in_rold), .sub(1'b1), .z(q_new)
  );

  lrp_recur #(.DW(DW)) u_fwd (
    .clk(clk), .rst_n(rst_n), .start(fwd_start), .step(fwd_step),
    .q_in(q_new), .prev(alpha_prev)
  );

  // metric slot holds the forward metric, then is overwritten by R_new
  assign m_wdata = bwd_step ? r_new : alpha_prev;

  lrp_store #(.DW(DW), .MAXW(MAXW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .q_we(fwd_step), .m_we(fwd_step | bwd_step), .waddr(idx),
    .q_wdata(q_new), .m_wdata(m_wdata),
    .raddr(idx), .q_rd(q_rd), .m_rd(m_rd)
  );

  lrp_recur #(.DW(DW)) u_bwd (
    .clk(clk), .rst_n(rst_n), .start(bwd_start), .step(bwd_step),
    .q_in(q_rd), .prev(beta_prev)
  );

  lrp_phi #(.DW(DW)) u_rmsg (
    .x(m_rd), .y(beta_prev), .z(r_new)
  );

  lrp_satadd #(.DW(DW)) u_lamadd (
    .a(q_rd), .b(m_rd), .sub(1'b0), .z(lam_upd)
  );

  assign out_lam  = lam_upd;
  assign out_rnew = m_rd;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lam) && $stable(out_rnew))); // R7
  AST_IO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R9
endmodule

// File: tb/tb_ldpc_row_proc.sv
`timescale 1ns/1ps
module tb_ldpc_row_proc;
  localparam int DW = 10, MAXW = 20, CW = 5;
  localparam int MAXI = 511, MINI = -512;
  localparam int NV = 8;
  // {row_wt driven, beats sent, seed, range kind, stall kind}
  localparam int TBL [NV][5] = '{
    '{2, 2, 11, 0, 0}, '{20, 20, 23, 1, 0}, '{7, 7, 5, 2, 1},
    '{13, 13, 77, 1, 2}, '{5, 5, 91, 0, 1}, '{31, 20, 3, 1, 2},
    '{0, 2, 45, 0, 2}, '{1, 2, 8, 1, 1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [CW-1:0] row_wt;
  logic signed [DW-1:0] in_lam, in_rold, out_lam, out_rnew;

  ldpc_row_proc #(.DW(DW), .MAXW(MAXW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .row_wt(row_wt), .in_valid(in_valid),
    .in_ready(in_ready), .in_lam(in_lam), .in_rold(in_rold),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_lam(out_lam), .out_rnew(out_rnew)
  );

  int checks = 0, fails = 0;
  int lam_v [MAXW], rold_v [MAXW], exp_lam [MAXW], exp_r [MAXW];
  int got_lam [MAXW], got_r [MAXW];
  int unsigned rng = 32'd1;
  bit done = 0;

  function automatic int sat(int v);
    return (v > MAXI) ? MAXI : (v < MINI) ? MINI : v;
  endfunction

  function automatic int phi(int x, int y);
    int mx, s;
    mx = (x > y) ? x : y;
    s  = x + y;
    return sat(mx - ((s > 0) ? s : 0));
  endfunction

  function automatic int nxt();
    rng = rng * 32'd1103515245 + 32'd12345;
    return int'(rng >> 8);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic model(int n);
    int q [MAXW];
    int ap [MAXW];
    int a, b;
    a = MINI;
    for (int k = 0; k < n; k++) begin
      q[k] = sat(lam_v[k] - rold_v[k]);
      ap[k] = a;
      a = phi(a, q[k]);
    end
    b = MINI;
    for (int k = n - 1; k >= 0; k--) begin
      exp_r[k] = phi(ap[k], b);
      exp_lam[k] = sat(q[k] + exp_r[k]);
      b = phi(b, q[k]);
    end
  endtask

  task automatic run_row(int wt_drv, int n, int stall, string tag);
    int sent = 0, rcv = 0, guard = 0, excl = 0, hl = 0, hr = 0;
    bit hold = 0, post = 0;
    while (rcv < n && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (hold) begin
        chk(out_valid && out_lam == DW'(hl) && out_rnew == DW'(hr), "R7",
            {tag, " held lam"}, int'(out_lam), hl);
        hold = 0;
      end
      if (sent < n) begin
        in_valid = 1'b1;
        in_lam   = DW'(lam_v[sent]);
        in_rold  = DW'(rold_v[sent]);
        row_wt   = (sent == 0) ? CW'(wt_drv) : CW'(nxt() % 32);
        if (in_ready) begin
          sent++;
          post = (sent == n);
        end
      end else begin
        in_valid = 1'b0;
        if (post) begin
          chk(!in_ready, "R1", {tag, " in_ready after last beat"}, int'(in_ready), 0);
          post = 0;
        end
      end
      out_ready = (stall == 0) ? 1'b1 : (stall == 1) ? guard[0] : nxt() % 3 != 0;
      if (in_ready && out_valid) excl++;
      if (out_valid && out_ready) begin
        got_lam[rcv] = int'(out_lam);
        got_r[rcv]   = int'(out_rnew);
        rcv++;
      end else if (out_valid) begin
        hold = 1;
        hl = int'(out_lam);
        hr = int'(out_rnew);
      end
    end
    if (guard >= 4000) chk(0, "R6", {tag, " watchdog on row"}, rcv, n);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R6", {tag, " idle after row"}, int'(out_valid), 0);
    chk(excl == 0, "R9", {tag, " in_ready with out_valid"}, excl, 0);
    for (int k = 0; k < n; k++) begin
      chk(got_r[k] == exp_r[k], "R3 R4", {tag, " R_new"}, got_r[k], exp_r[k]);
      chk(got_lam[k] == exp_lam[k], "R5", {tag, " LLR"}, got_lam[k], exp_lam[k]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(0, "R6", "global watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    row_wt = '0; in_lam = '0; in_rold = '0;
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid, "R8", "during reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R8", "after reset", int'(in_ready), 1);

    // table of rows, expectations from the equation model
    for (int t = 0; t < NV; t++) begin
      rng = TBL[t][2];
      for (int k = 0; k < TBL[t][1]; k++) begin
        case (TBL[t][3])
          0: begin lam_v[k] = nxt() % 128 - 64; rold_v[k] = nxt() % 64 - 32; end
          1: begin lam_v[k] = nxt() % 1024 - 512; rold_v[k] = nxt() % 1024 - 512; end
          default: begin lam_v[k] = nxt() % 512 - 256; rold_v[k] = 0; end
        endcase
      end
      model(TBL[t][1]);
      run_row(TBL[t][0], TBL[t][1], TBL[t][4], $sformatf("row%0d", t));
    end

    // directed: weight 3 worked by hand, R_old zero (R3 R4 R5)
    lam_v[0] = 10; lam_v[1] = 20; lam_v[2] = 30;
    rold_v[0] = 0; rold_v[1] = 0; rold_v[2] = 0;
    exp_r[0] = -20; exp_r[1] = -10; exp_r[2] = -10;
    exp_lam[0] = -10; exp_lam[1] = 10; exp_lam[2] = 20;
    run_row(3, 3, 1, "hand3");

    // directed: Q saturates at both ends (R2)
    lam_v[0] = 511; rold_v[0] = -512; lam_v[1] = -512; rold_v[1] = 511;
    exp_r[0] = -512; exp_r[1] = 511; exp_lam[0] = -1; exp_lam[1] = -1;
    run_row(2, 2, 0, "R2 qsat");

    // directed: updated LLR saturates high (R5)
    lam_v[0] = 300; rold_v[0] = 0; lam_v[1] = 300; rold_v[1] = 0;
    exp_r[0] = 300; exp_r[1] = 300; exp_lam[0] = 511; exp_lam[1] = 511;
    run_row(2, 2, 2, "R5 lamsat");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule